// File: doc/BRIEF.md
# PCI parity generator and checker

This block creates and checks bus parity for one agent that can be either the initiator or the selected target of a transaction. Every rising clock edge it samples the framing, ready and multiplexed address/data lines, along with role and direction qualifiers from the surrounding bus interface. It then forms the even-parity bit over the 32 address/data lines and the 4 command/byte-enable lines. In the following clock it presents that bit, together with an output enable, whenever the agent owned the phase just sampled.

For phases that another agent drove and this agent receives, the block compares the parity bit one clock later with a copy it computed itself. A bad data phase pulls the data-error line low for one clock, and that clock comes two edges after the phase. A bad address phase pulls the system-error line low for a single clock at the same offset. Two enables gate the two error lines. Two sticky status bits record every detection whatever the enables are set to, and only reset clears them.

A small bus tracker has three states. BUS_IDLE goes to BUS_DATA when FRAME# is sampled low (START). BUS_DATA stays in place while FRAME# is held low (HOLD). When FRAME# rises it goes to BUS_LAST (FINAL), or straight back to BUS_IDLE if the final phase completes, or if IRDY# is also high, on that same edge (RETIRE). BUS_LAST goes to BUS_IDLE when that phase completes or IRDY# is released (RETIRE). A separate pending-check register holds CHK_NONE, CHK_ADDR or CHK_DATA for the clock after each phase.

Top module: `pci_parity_unit`

## Requirements
- R1: par_out equals the XOR of the 32 AD bits and the 4 C/BE# bits sampled on the previous edge, so those 36 bits plus par_out carry an even number of ones.
- R2: An address phase is FRAME# sampled low while the tracker is in BUS_IDLE. In the clock after it, par_oe is 1 exactly when own_master was 1 at that edge.
- R3: For a write (xfer_write=1) with own_master=1, par_oe is 1 in every clock that follows an edge where IRDY# was low during a data phase, wait clocks with TRDY# high included.
- R4: For a read (xfer_write=0) with own_target=1, par_oe is 1 in every clock that follows an edge where TRDY# was low during a data phase. After any other edge, and after phases owned by another agent, par_oe is 0.
- R5: A data phase completes when IRDY# and TRDY# are both low at an edge. If this agent is its receiver (target of a write or master of a read), par_in at the next edge is compared with the expected bit. On a mismatch perr_n is 0 for the one clock after that next edge, once per bad phase. Edges without completion are never checked.
- R6: When own_master=0, the address phase parity is checked on the next edge. A mismatch drives serr_n to 0 for exactly one clock.
- R7: With perr_en=0, perr_n stays 1. With serr_en=0, serr_n stays 1. Detection and the status bits still work.
- R8: A data parity error in a transaction flagged special_cyc=1 leaves perr_n at 1 but sets sts_data_perr.
- R9: sts_data_perr and sts_addr_perr become 1 on the clock after a detected data or address error and hold until reset.
- R10: While rst_n is 0: par_oe=0, perr_n=1, serr_n=1 and both status bits are 0.
- R11: FRAME# held low within a transaction is never taken for a new address phase. FRAME# sampled low on the edge right after a final data phase completes starts a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_n | input | 1 | Sampled FRAME#, active low |
| irdy_n | input | 1 | Sampled IRDY#, active low |
| trdy_n | input | 1 | Sampled TRDY#, active low |
| ad | input | 32 | Sampled address/data lines |
| cbe_n | input | 4 | Sampled command/byte-enable lines |
| par_in | input | 1 | Sampled PAR line |
| own_master | input | 1 | This agent is the initiator of the current transaction |
| own_target | input | 1 | This agent is the selected target of the current transaction |
| xfer_write | input | 1 | 1 for a write transaction, 0 for a read |
| special_cyc | input | 1 | Current transaction is a broadcast special cycle |
| perr_en | input | 1 | Allows data parity errors onto perr_n |
| serr_en | input | 1 | Allows address parity errors onto serr_n |
| par_out | output | 1 | Parity bit to drive on PAR |
| par_oe | output | 1 | Drive enable for PAR |
| perr_n | output | 1 | Data parity error, active low (1 means released) |
| serr_n | output | 1 | Address parity error pulse, active low (1 means released) |
| sts_data_perr | output | 1 | Sticky data parity error status |
| sts_addr_perr | output | 1 | Sticky address parity error status |

## Verification
The bench drives a burst in which a wait clock (IRDY# low, TRDY# high) is followed by a corrupted PAR. A design that checked every IRDY# clock rather than only completed phases would pulse perr_n on that wait clock. The same burst has two bad phases back to back, and these must give exactly two consecutive low clocks: a checker that stretched or merged its errors would get the count wrong. The burst also holds FRAME# low through several clocks with corrupted PAR, so a tracker that re-read a held FRAME# as a fresh address phase would fire serr_n or assert par_oe in clocks it does not own. A fast back-to-back address phase, the enables switched off, a special cycle, and a master that sees bad write parity it drove itself close out the cases where a design could report an error it must not report, or miss one it must.

// File: rtl/pcipar_pkg.sv
package pcipar_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE = 2'd0,
        BUS_DATA = 2'd1,
        BUS_LAST = 2'd2
    } bus_state_e;

    typedef enum logic [1:0] {
        CHK_NONE = 2'd0,
        CHK_ADDR = 2'd1,
        CHK_DATA = 2'd2
    } chk_kind_e;

endpackage

// File: rtl/pcipar_bus_tracker.sv
module pcipar_bus_tracker
    import pcipar_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_n,
    input  logic irdy_n,
    input  logic trdy_n,
    output logic addr_phase,
    output logic irdy_seen,
    output logic trdy_seen,
    output logic xfer_done
);

    bus_state_e st_q;
    bus_state_e st_d;
    logic       in_data;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= BUS_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // phase decode for the current edge
    always_comb begin
        in_data    = (st_q != BUS_IDLE);
        addr_phase = (st_q == BUS_IDLE) && !frame_n;
        irdy_seen  = in_data && !irdy_n;
        trdy_seen  = in_data && !trdy_n;
        xfer_done  = in_data && !irdy_n && !trdy_n;
    end

    // transitions: START, HOLD, FINAL, RETIRE
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BUS_IDLE: begin
                if (!frame_n) begin
                    st_d = BUS_DATA;
                end
            end
            BUS_DATA: begin
                if (frame_n) begin
                    if (xfer_done || irdy_n) begin
                        st_d = BUS_IDLE;
                    end else begin
                        st_d = BUS_LAST;
                    end
                end
            end
            BUS_LAST: begin
                if (xfer_done || irdy_n) begin
                    st_d = BUS_IDLE;
                end
            end
            default: st_d = BUS_IDLE;
        endcase
    end

    assert_no_double_addr_R11: assert property (
        @(posedge clk) disable iff (!rst_n)
        addr_phase |=> !addr_phase
    ) else $error("address phase recognised on two consecutive edges");

endmodule

// File: rtl/pcipar_xor_tree.sv
module pcipar_xor_tree #(
    parameter int W = 9
) (
    input  logic [W-1:0] vec,
    output logic         odd
);

    logic [W-1:0] chain;

    assign chain[0] = vec[0];

    for (genvar gi = 1; gi < W; gi++) begin : g_link
        assign chain[gi] = chain[gi-1] ^ vec[gi];
    end

    assign odd = chain[W-1];

endmodule

// File: rtl/pcipar_drive.sv
module pcipar_drive
    import pcipar_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      bus_odd,
    input  logic      drive_now,
    input  chk_kind_e chk_now,
    input  logic      spc_now,
    input  logic      activity,
    output logic      par_q,
    output logic      par_oe,
    output chk_kind_e chk_q,
    output logic      spc_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            par_q  <= 1'b0;
            par_oe <= 1'b0;
            chk_q  <= CHK_NONE;
            spc_q  <= 1'b0;
        end else begin
            par_q  <= bus_odd;
            par_oe <= drive_now;
            chk_q  <= chk_now;
            spc_q  <= spc_now;
        end
    end

    assert_oe_needs_activity_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        par_oe |-> $past(activity)
    ) else $error("PAR enabled after an edge with no bus phase");

endmodule

// File: rtl/pcipar_check.sv
module pcipar_check
    import pcipar_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  chk_kind_e chk_q,
    input  logic      spc_q,
    input  logic      exp_par,
    input  logic      par_in,
    input  logic      perr_en,
    input  logic      serr_en,
    output logic      perr_n,
    output logic      serr_n,
    output logic      sts_data_perr,
    output logic      sts_addr_perr
);

    logic mismatch;
    logic data_bad;
    logic addr_bad;
    logic perr_q;
    logic serr_q;

    always_comb begin
        mismatch = (par_in != exp_par);
        data_bad = (chk_q == CHK_DATA) && mismatch;
        addr_bad = (chk_q == CHK_ADDR) && mismatch;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            perr_q        <= 1'b0;
            serr_q        <= 1'b0;
            sts_data_perr <= 1'b0;
            sts_addr_perr <= 1'b0;
        end else begin
            perr_q        <= data_bad && perr_en && !spc_q;
            serr_q        <= addr_bad && serr_en;
            sts_data_perr <= sts_data_perr || data_bad;
            sts_addr_perr <= sts_addr_perr || addr_bad;
        end
    end

    assign perr_n = !perr_q;
    assign serr_n = !serr_q;

    assert_serr_one_clock_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        !serr_n |=> serr_n
    ) else $error("serr_n held low for more than one clock");

    assert_perr_gated_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        !perr_n |-> $past(perr_en)
    ) else $error("perr_n driven with its enable off");

    assert_serr_gated_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        !serr_n |-> $past(serr_en)
    ) else $error("serr_n driven with its enable off");

    assert_data_sticky_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        sts_data_perr |=> sts_data_perr
    ) else $error("data status cleared without reset");

    assert_addr_sticky_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        sts_addr_perr |=> sts_addr_perr
    ) else $error("address status cleared without reset");

endmodule

// File: rtl/pci_parity_unit.sv
module pci_parity_unit
    import pcipar_pkg::*;
#(
    parameter int AD_W      = 32,
    parameter int LANE_BITS = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        frame_n,
    input  logic                        irdy_n,
    input  logic                        trdy_n,
    input  logic [AD_W-1:0]             ad,
    input  logic [AD_W/LANE_BITS-1:0]   cbe_n,
    input  logic                        par_in,
    input  logic                        own_master,
    input  logic                        own_target,
    input  logic                        xfer_write,
    input  logic                        special_cyc,
    input  logic                        perr_en,
    input  logic                        serr_en,
    output logic                        par_out,
    output logic                        par_oe,
    output logic                        perr_n,
    output logic                        serr_n,
    output logic                        sts_data_perr,
    output logic                        sts_addr_perr
);

    localparam int LANES = AD_W / LANE_BITS;

    logic             addr_phase;
    logic             irdy_seen;
    logic             trdy_seen;
    logic             xfer_done;
    logic [LANES-1:0] lane_odd;
    logic             bus_odd;
    logic             drive_now;
    logic             receiver;
    logic             activity;
    chk_kind_e        chk_now;
    chk_kind_e        chk_q;
    logic             spc_q;

    pcipar_bus_tracker u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_n    (frame_n),
        .irdy_n     (irdy_n),
        .trdy_n     (trdy_n),
        .addr_phase (addr_phase),
        .irdy_seen  (irdy_seen),
        .trdy_seen  (trdy_seen),
        .xfer_done  (xfer_done)
    );

    // each lane folds its data byte with its own command/enable bit
    for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
        pcipar_xor_tree #(.W(LANE_BITS + 1)) u_lane (
            .vec ({cbe_n[gl], ad[gl*LANE_BITS +: LANE_BITS]}),
            .odd (lane_odd[gl])
        );
    end

    pcipar_xor_tree #(.W(LANES)) u_fold (
        .vec (lane_odd),
        .odd (bus_odd)
    );

    always_comb begin
        receiver  = (own_target && xfer_write) || (own_master && !xfer_write);
        drive_now = (addr_phase && own_master)
                 || (irdy_seen && own_master && xfer_write)
                 || (trdy_seen && own_target && !xfer_write);
        activity  = !frame_n || !irdy_n || !trdy_n;
        if (addr_phase && !own_master) begin
            chk_now = CHK_ADDR;
        end else if (xfer_done && receiver) begin
            chk_now = CHK_DATA;
        end else begin
            chk_now = CHK_NONE;
        end
    end

    pcipar_drive u_drive (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_odd   (bus_odd),
        .drive_now (drive_now),
        .chk_now   (chk_now),
        .spc_now   (special_cyc),
        .activity  (activity),
        .par_q     (par_out),
        .par_oe    (par_oe),
        .chk_q     (chk_q),
        .spc_q     (spc_q)
    );

    pcipar_check u_check (
        .clk           (clk),
        .rst_n         (rst_n),
        .chk_q         (chk_q),
        .spc_q         (spc_q),
        .exp_par       (par_out),
        .par_in        (par_in),
        .perr_en       (perr_en),
        .serr_en       (serr_en),
        .perr_n        (perr_n),
        .serr_n        (serr_n),
        .sts_data_perr (sts_data_perr),
        .sts_addr_perr (sts_addr_perr)
    );

    assert_perr_follows_xfer_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        !perr_n |-> $past(!irdy_n && !trdy_n, 2)
    ) else $error("perr_n low without a completed phase two edges earlier");

endmodule

// File: tb/sim_pci_parity_unit.sv
`timescale 1ns/1ps
module sim_pci_parity_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        frame_n, irdy_n, trdy_n;
    logic [31:0] ad;
    logic [3:0]  cbe_n;
    logic        par_in;
    logic        own_master, own_target, xfer_write, special_cyc;
    logic        perr_en, serr_en;
    logic        par_out, par_oe, perr_n, serr_n;
    logic        sts_data_perr, sts_addr_perr;

    int n_chk  = 0;
    int n_fail = 0;
    logic exp_sd = 1'b0;
    logic exp_sa = 1'b0;

    always #2 clk = ~clk;

    pci_parity_unit u0 (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .trdy_n(trdy_n), .ad(ad), .cbe_n(cbe_n), .par_in(par_in),
        .own_master(own_master), .own_target(own_target),
        .xfer_write(xfer_write), .special_cyc(special_cyc),
        .perr_en(perr_en), .serr_en(serr_en), .par_out(par_out),
        .par_oe(par_oe), .perr_n(perr_n), .serr_n(serr_n),
        .sts_data_perr(sts_data_perr), .sts_addr_perr(sts_addr_perr)
    );

    typedef struct packed {
        logic        m, t, w, spc, pen, sen, acor, dcor;
        logic [31:0] addr;
        logic [3:0]  cmd;
        logic [31:0] data;
        logic [3:0]  be;
    } vec_t;

    // single-phase transactions: roles, enables, corruptions, bus values
    localparam vec_t VT [8] = '{
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1, 32'h1000_0040, 4'b0111, 32'hDEAD_BEEF, 4'b0000},
        '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1, 32'h2000_0100, 4'b0111, 32'h0F0F_1234, 4'b0011},
        '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0, 32'h2000_0104, 4'b0110, 32'h8000_0001, 4'b0000},
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1, 32'h3000_0008, 4'b0110, 32'h5555_AAAA, 4'b1100},
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1, 32'h2000_0200, 4'b0111, 32'h1111_1111, 4'b0000},
        '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1, 32'h0000_0000, 4'b0001, 32'h0000_00A5, 4'b1110},
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1, 32'h4000_0000, 4'b0111, 32'h7FFF_FFFF, 4'b0000},
        '{1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0, 32'h0000_0000, 4'b0111, 32'hFFFF_FFFF, 4'b1111}
    };

    // burst: addr, done, wait, done, final done, idle x3 (bit index = cycle)
    localparam logic [7:0] B_FRAME = 8'b1111_0000;
    localparam logic [7:0] B_IRDY  = 8'b1110_0001;
    localparam logic [7:0] B_TRDY  = 8'b1110_0101;
    localparam logic [7:0] B_COR   = 8'b0011_1000;
    localparam logic [31:0] B_AD [8] = '{32'h0000_2000, 32'h1234_5678, 32'hA5A5_0F0F,
        32'hA5A5_0F0F, 32'h0000_0001, 32'h0, 32'h0, 32'h0};
    localparam logic [3:0] B_BE [8] = '{4'b0111, 4'b0000, 4'b0011, 4'b0011,
        4'b1110, 4'b1111, 4'b1111, 4'b1111};

    function automatic logic ep(input logic [31:0] a, input logic [3:0] c);
        return ^{a, c};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    task automatic bus_idle();
        frame_n = 1'b1; irdy_n = 1'b1; trdy_n = 1'b1;
        ad = 32'h0; cbe_n = 4'hF; par_in = 1'b0;
    endtask

    task automatic check_status();
        check("R9 sts_data_perr", {31'b0, sts_data_perr}, {31'b0, exp_sd});
        check("R9 sts_addr_perr", {31'b0, sts_addr_perr}, {31'b0, exp_sa});
    endtask

    task automatic run_vec(input vec_t v);
        logic recv;
        recv = (v.t & v.w) | (v.m & ~v.w);
        own_master = v.m; own_target = v.t; xfer_write = v.w;
        special_cyc = v.spc; perr_en = v.pen; serr_en = v.sen;
        // address phase
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; trdy_n = 1'b1;
        ad = v.addr; cbe_n = v.cmd; par_in = 1'b0;
        @(negedge clk);
        check("R2 par_oe after address", {31'b0, par_oe}, {31'b0, v.m});
        if (v.m) check("R1 address parity", {31'b0, par_out}, {31'b0, ep(v.addr, v.cmd)});
        // single data phase, final
        frame_n = 1'b1; irdy_n = 1'b0; trdy_n = 1'b0;
        ad = v.data; cbe_n = v.be; par_in = ep(v.addr, v.cmd) ^ v.acor;
        @(negedge clk);
        check("R6/R7 serr_n", {31'b0, serr_n}, {31'b0, ~(v.acor & ~v.m & v.sen)});
        check("R3/R4 par_oe after data", {31'b0, par_oe},
              {31'b0, (v.m & v.w) | (v.t & ~v.w)});
        if ((v.m & v.w) | (v.t & ~v.w))
            check("R1 data parity", {31'b0, par_out}, {31'b0, ep(v.data, v.be)});
        if (v.acor & ~v.m) exp_sa = 1'b1;
        bus_idle();
        par_in = ep(v.data, v.be) ^ v.dcor;
        @(negedge clk);
        check("R5/R7/R8 perr_n", {31'b0, perr_n},
              {31'b0, ~(v.dcor & recv & v.pen & ~v.spc)});
        check("R6 serr_n released", {31'b0, serr_n}, 32'd1);
        check("R4 par_oe idle", {31'b0, par_oe}, 32'd0);
        if (v.dcor & recv) exp_sd = 1'b1;
        par_in = 1'b0;
        @(negedge clk);
        check("R5 perr_n one clock", {31'b0, perr_n}, 32'd1);
        check_status();
    endtask

    task automatic drv_burst(input int k);
        frame_n = B_FRAME[k]; irdy_n = B_IRDY[k]; trdy_n = B_TRDY[k];
        ad = B_AD[k]; cbe_n = B_BE[k];
        par_in = (k == 0) ? 1'b0 : (ep(B_AD[k-1], B_BE[k-1]) ^ B_COR[k]);
    endtask

    task automatic run_burst(input logic m, input logic t, input logic w);
        logic recv;
        logic eoe;
        logic eperr;
        recv = (t & w) | (m & ~w);
        own_master = m; own_target = t; xfer_write = w;
        special_cyc = 1'b0; perr_en = 1'b1; serr_en = 1'b1;
        @(negedge clk);
        drv_burst(0);
        for (int j = 1; j <= 8; j++) begin
            @(negedge clk);
            if (j == 1) eoe = m;
            else if (j <= 5) eoe = (m & w & ~B_IRDY[j-1]) | (t & ~w & ~B_TRDY[j-1]);
            else eoe = 1'b0;
            check(w ? "R3 burst par_oe" : "R4 burst par_oe", {31'b0, par_oe}, {31'b0, eoe});
            if (eoe) check("R1 burst parity", {31'b0, par_out},
                           {31'b0, ep(B_AD[j-1], B_BE[j-1])});
            eperr = (j >= 3) && !B_IRDY[j-2] && !B_TRDY[j-2] && B_COR[j-1] && recv;
            check("R5 burst perr_n", {31'b0, perr_n}, {31'b0, ~eperr});
            check("R11 burst serr_n", {31'b0, serr_n}, 32'd1);
            if (eperr) exp_sd = 1'b1;
            if (j < 8) drv_burst(j);
            else bus_idle();
        end
        check_status();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        bus_idle();
        own_master = 1'b0; own_target = 1'b0; xfer_write = 1'b0;
        special_cyc = 1'b0; perr_en = 1'b1; serr_en = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 par_oe in reset", {31'b0, par_oe}, 32'd0);
        check("R10 perr_n in reset", {31'b0, perr_n}, 32'd1);
        check("R10 serr_n in reset", {31'b0, serr_n}, 32'd1);
        check_status();
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 par_oe after release", {31'b0, par_oe}, 32'd0);

        for (int i = 0; i < 8; i++) run_vec(VT[i]);

        // bursts with a wait clock and consecutive bad phases
        run_burst(1'b0, 1'b1, 1'b1);
        run_burst(1'b1, 1'b0, 1'b1);
        run_burst(1'b0, 1'b1, 1'b0);
        run_burst(1'b1, 1'b0, 1'b0);

        // fast back-to-back: new address on the edge after the final phase (R11)
        own_master = 1'b0; own_target = 1'b1; xfer_write = 1'b1;
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; trdy_n = 1'b1;
        ad = 32'h5000_0010; cbe_n = 4'b0111; par_in = 1'b0;
        @(negedge clk);
        frame_n = 1'b1; irdy_n = 1'b0; trdy_n = 1'b0;
        par_in = ep(32'h5000_0010, 4'b0111);
        ad = 32'h0000_00FF; cbe_n = 4'b0000;
        @(negedge clk);
        check("R11 target write, no drive", {31'b0, par_oe}, 32'd0);
        own_master = 1'b1; own_target = 1'b0;
        frame_n = 1'b0; irdy_n = 1'b1; trdy_n = 1'b1;
        par_in = ep(32'h0000_00FF, 4'b0000);
        ad = 32'h6000_0020; cbe_n = 4'b0111;
        @(negedge clk);
        check("R11 back-to-back address drive", {31'b0, par_oe}, 32'd1);
        check("R2 back-to-back address parity", {31'b0, par_out},
              {31'b0, ep(32'h6000_0020, 4'b0111)});
        check("R5 good parity, perr_n idle", {31'b0, perr_n}, 32'd1);
        frame_n = 1'b1; irdy_n = 1'b0; trdy_n = 1'b0;
        par_in = ep(32'h6000_0020, 4'b0111);
        ad = 32'h0000_1234; cbe_n = 4'b0000;
        @(negedge clk);
        check("R3 back-to-back write data drive", {31'b0, par_oe}, 32'd1);
        bus_idle();
        @(negedge clk);
        check_status();

        // reset during a transaction clears status and releases drivers
        own_master = 1'b1; own_target = 1'b0; xfer_write = 1'b1;
        frame_n = 1'b0;
        ad = 32'h7000_0000; cbe_n = 4'b0111;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R10 par_oe on reset", {31'b0, par_oe}, 32'd0);
        exp_sd = 1'b0; exp_sa = 1'b0;
        check_status();
        bus_idle();
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 perr_n after reset", {31'b0, perr_n}, 32'd1);
        check("R10 serr_n after reset", {31'b0, serr_n}, 32'd1);

        summary();
        $finish;
    end

endmodule